// File: doc/BRIEF.md
# Frame-Synchronised Window Register Bank

This block keeps two copies of the per-window settings of a multi-window display controller. Software writes the working copy over a simple register bus. The logic downstream (blending, fetch) sees only the shadow copy. Each window's shadow copy takes the working values on a vertical-sync strobe, so a window never changes in the middle of a frame. Each window has the following settings: a display enable, a channel-path enable, a frame buffer start address, and a horizontal and vertical position.

Software can set a protect bit for any window in the global control word. While that bit is set, the window's shadow copy stays frozen through every vsync. This lets a change that spans several registers land all at once. Once the protect bit is cleared, the change lands on the next vsync. Every shadow value can be read back at a fixed address offset. Software can therefore compare the working and shadow start addresses to tell when a new buffer has been taken up.

Top module: `vsb_top`

## Requirements
- R1: While reset is asserted, and afterwards until the first write, every working value, every shadow value, every protect bit and every output reads as zero.
- R2: A write to a window register changes its working copy from the next clock. A read returns the working value at these addresses: window w (0-based) control at 0x10·(w+1) with the enable in bit 0, start address at +0x4 (32 bits), and position at +0x8 with x in bits [11:0] and y in bits [27:16]. Other bits read as zero.
- R3: On a clock where `vsync_i` is high and the window's protect bit is clear, the window's shadow copy takes the working values. The shadow outputs show them from the next clock.
- R4: While a window's protect bit (bit w of the global word at 0x00) is set, vsync leaves that window's shadow copy unchanged. Clearing the bit does not update the shadow copy by itself. The pending values land at the first vsync after the clear.
- R5: Clearing a window's enable bit leaves `win_en_o` high until the next vsync, and drops it then.
- R6: A write issued on the same clock as vsync does not reach the shadow copy at that vsync. The shadow copy takes the value that was in the working copy before the write. The written value lands at the following vsync.
- R7: Setting address bit 7 on a read returns the shadow copy instead of the working copy. At 0x80 the read returns the shadow channel-path enables in their global-word positions.
- R8: The channel-path enable of window w is bit 16+w of the global word. It reaches `chan_en_o` only through the vsync copy, under that window's protect bit.
- R9: A protect bit freezes only its own window. Other windows update at the same vsync.
- R10: Reads and writes to unmapped addresses have no effect and read as zero. Writes with address bit 7 set are ignored, because the shadow copies are read-only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| vsync_i | input | 1 | One-cycle vertical sync strobe |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 8 | Write byte address |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 8 | Read byte address |
| rd_data_o | output | 32 | Read data (combinational) |
| win_en_o | output | 5 | Shadow display enable per window |
| chan_en_o | output | 5 | Shadow channel-path enable per window |
| base_o | output | 160 | Shadow start address, window w at [32w+31:32w] |
| pos_x_o | output | 60 | Shadow x position, window w at [12w+11:12w] |
| pos_y_o | output | 60 | Shadow y position, window w at [12w+11:12w] |

## Verification
The main vector walk tries several patterns. First it writes and then strobes vsync, which separates the working copy from the shadow copy. Next it sets protect on one window while another window updates, which separates a per-window freeze from a global one. It then clears protect without a strobe, which shows that the clear alone does not copy. Finally it writes to the shadow and unmapped space, which shows that those writes are dropped. Directed tests place a write on the same clock as vsync to show which value the shadow copy takes. They also watch the enable output across a disable to see exactly when it falls.

// File: rtl/vsb_pkg.sv
package vsb_pkg;
  parameter int DATA_W   = 32;
  parameter int BUS_AW   = 8;
  parameter int BASE_W   = 32;
  parameter int POS_W    = 12;
  localparam int REG_LSB  = 2;
  localparam int SLOT_LSB = 4;
  localparam int SLOT_W   = BUS_AW - 1 - SLOT_LSB;
  localparam int POSY_LSB = 16;
  localparam int CHAN_LSB = 16;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_BASE = 2'd1,
    REG_POS  = 2'd2,
    REG_NONE = 2'd3
  } wreg_e;

  typedef struct packed {
    logic              en;
    logic              chan;
    logic [BASE_W-1:0] base;
    logic [POS_W-1:0]  px;
    logic [POS_W-1:0]  py;
  } win_cfg_t;

  function automatic logic [DATA_W-1:0] pack_reg(win_cfg_t c, wreg_e r);
    logic [DATA_W-1:0] v;
    v = '0;
    case (r)
      REG_CTRL: v[0] = c.en;
      REG_BASE: v[BASE_W-1:0] = c.base;
      REG_POS: begin
        v[POS_W-1:0]          = c.px;
        v[POSY_LSB +: POS_W]  = c.py;
      end
      default: v = '0;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/vsb_decode.sv
module vsb_decode
  import vsb_pkg::*;
#(
  parameter int NUM_WIN = 5
) (
  input  logic               wr_en_i,
  input  logic [BUS_AW-1:0]  wr_addr_i,
  output logic               glob_we_o,
  output logic [NUM_WIN-1:0] win_we_o,
  output wreg_e              sel_o
);
  logic              shadow_sp;
  logic              aligned;
  logic [SLOT_W-1:0] slot;

  always_comb begin
    shadow_sp = wr_addr_i[BUS_AW-1];
    aligned   = (wr_addr_i[REG_LSB-1:0] == '0);
    slot      = wr_addr_i[SLOT_LSB +: SLOT_W];
    sel_o     = wreg_e'(wr_addr_i[REG_LSB +: 2]);
    glob_we_o = wr_en_i && !shadow_sp && aligned &&
                (slot == '0) && (sel_o == REG_CTRL);
  end

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_we
    assign win_we_o[w] = wr_en_i && !shadow_sp && aligned &&
                         (slot == SLOT_W'(w + 1)) && (sel_o != REG_NONE);
  end
endmodule

// File: rtl/vsb_window.sv
module vsb_window
  import vsb_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_n,
  input  logic              vsync_i,
  input  logic              prot_i,
  input  logic              chan_i,
  input  logic              we_i,
  input  wreg_e             sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  output win_cfg_t          wk_o,
  output win_cfg_t          sh_o
);
  win_cfg_t wk_q, wk_d, wk_view;
  win_cfg_t sh_q;
  logic     wk_ce, sh_ce;

  // next-state for the working copy
  always_comb begin
    wk_d      = wk_q;
    wk_d.chan = 1'b0;
    case (sel_i)
      REG_CTRL: wk_d.en = wdata_i[0];
      REG_BASE: wk_d.base = wdata_i[BASE_W-1:0];
      REG_POS: begin
        wk_d.px = wdata_i[POS_W-1:0];
        wk_d.py = wdata_i[POSY_LSB +: POS_W];
      end
      default: wk_d = wk_q;
    endcase
    wk_view      = wk_q;
    wk_view.chan = chan_i;
    wk_ce        = we_i;
    sh_ce        = vsync_i && !prot_i;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      wk_q <= '0;
      sh_q <= '0;
    end else begin
      if (wk_ce) wk_q <= wk_d;
      if (sh_ce) sh_q <= wk_view;
    end
  end

  assign wk_o = wk_view;
  assign sh_o = sh_q;

  // R3: shadow moves only on a vsync strobe
  p_quiet_between_r3: assert property (@(posedge clk_i) disable iff (!rst_n)
    !vsync_i |=> $stable(sh_q));
  // R3: an unprotected vsync brings the working view across
  p_take_working_r3: assert property (@(posedge clk_i) disable iff (!rst_n)
    (vsync_i && !prot_i) |=> (sh_q == $past(wk_view)));
  // R4: protect freezes the shadow through a vsync
  p_frozen_r4: assert property (@(posedge clk_i) disable iff (!rst_n)
    (vsync_i && prot_i) |=> $stable(sh_q));
endmodule

// File: rtl/vsb_rdmux.sv
module vsb_rdmux
  import vsb_pkg::*;
#(
  parameter int NUM_WIN = 5
) (
  input  logic [BUS_AW-1:0]  rd_addr_i,
  input  win_cfg_t           wk_i [NUM_WIN],
  input  win_cfg_t           sh_i [NUM_WIN],
  input  logic [NUM_WIN-1:0] prot_i,
  input  logic [NUM_WIN-1:0] chanw_i,
  output logic [DATA_W-1:0]  rd_data_o
);
  logic              shadow_sp;
  logic              aligned;
  logic [SLOT_W-1:0] slot;
  wreg_e             sel;

  always_comb begin
    shadow_sp = rd_addr_i[BUS_AW-1];
    aligned   = (rd_addr_i[REG_LSB-1:0] == '0);
    slot      = rd_addr_i[SLOT_LSB +: SLOT_W];
    sel       = wreg_e'(rd_addr_i[REG_LSB +: 2]);
    rd_data_o = '0;
    if (aligned) begin
      if (slot == '0) begin
        if (sel == REG_CTRL) begin
          for (int w = 0; w < NUM_WIN; w++) begin
            if (shadow_sp) begin
              rd_data_o[CHAN_LSB + w] = sh_i[w].chan;
            end else begin
              rd_data_o[w]            = prot_i[w];
              rd_data_o[CHAN_LSB + w] = chanw_i[w];
            end
          end
        end
      end else begin
        for (int w = 0; w < NUM_WIN; w++) begin
          if (slot == SLOT_W'(w + 1))
            rd_data_o = pack_reg(shadow_sp ? sh_i[w] : wk_i[w], sel);
        end
      end
    end
  end
endmodule

// File: rtl/vsb_top.sv
module vsb_top
  import vsb_pkg::*;
#(
  parameter int NUM_WIN = 5
) (
  input  logic                      clk_i,
  input  logic                      rst_n_i,
  input  logic                      vsync_i,
  input  logic                      wr_en_i,
  input  logic [BUS_AW-1:0]         wr_addr_i,
  input  logic [DATA_W-1:0]         wr_data_i,
  input  logic [BUS_AW-1:0]         rd_addr_i,
  output logic [DATA_W-1:0]         rd_data_o,
  output logic [NUM_WIN-1:0]        win_en_o,
  output logic [NUM_WIN-1:0]        chan_en_o,
  output logic [NUM_WIN*BASE_W-1:0] base_o,
  output logic [NUM_WIN*POS_W-1:0]  pos_x_o,
  output logic [NUM_WIN*POS_W-1:0]  pos_y_o
);
  localparam int MAX_WIN = (1 << SLOT_W) - 1;

  logic [1:0]         rst_sync_q;
  logic               rst_n;
  logic               glob_we;
  logic [NUM_WIN-1:0] win_we;
  wreg_e              sel;
  logic [NUM_WIN-1:0] prot_q, prot_d, chanw_q, chanw_d;
  win_cfg_t           wk [NUM_WIN];
  win_cfg_t           sh [NUM_WIN];

  initial begin
    if (NUM_WIN > MAX_WIN) $error("NUM_WIN exceeds address slots");
  end

  // asynchronous assert, synchronous release
  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) rst_sync_q <= '0;
    else          rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  vsb_decode #(.NUM_WIN(NUM_WIN)) u_dec (
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .glob_we_o (glob_we),
    .win_we_o  (win_we),
    .sel_o     (sel)
  );

  // global control word: protect bits and working channel enables
  always_comb begin
    prot_d  = wr_data_i[NUM_WIN-1:0];
    chanw_d = wr_data_i[CHAN_LSB +: NUM_WIN];
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      prot_q  <= '0;
      chanw_q <= '0;
    end else if (glob_we) begin
      prot_q  <= prot_d;
      chanw_q <= chanw_d;
    end
  end

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    vsb_window u_win (
      .clk_i   (clk_i),
      .rst_n   (rst_n),
      .vsync_i (vsync_i),
      .prot_i  (prot_q[w]),
      .chan_i  (chanw_q[w]),
      .we_i    (win_we[w]),
      .sel_i   (sel),
      .wdata_i (wr_data_i),
      .wk_o    (wk[w]),
      .sh_o    (sh[w])
    );
    assign win_en_o[w]                = sh[w].en;
    assign chan_en_o[w]               = sh[w].chan;
    assign base_o[w*BASE_W +: BASE_W] = sh[w].base;
    assign pos_x_o[w*POS_W +: POS_W]  = sh[w].px;
    assign pos_y_o[w*POS_W +: POS_W]  = sh[w].py;
  end

  vsb_rdmux #(.NUM_WIN(NUM_WIN)) u_rd (
    .rd_addr_i (rd_addr_i),
    .wk_i      (wk),
    .sh_i      (sh),
    .prot_i    (prot_q),
    .chanw_i   (chanw_q),
    .rd_data_o (rd_data_o)
  );

  // R10: a write reaches at most one target
  p_one_target_r10: assert property (@(posedge clk_i) disable iff (!rst_n)
    $onehot0({glob_we, win_we}));
  // R10: shadow space accepts no write
  p_shadow_ro_r10: assert property (@(posedge clk_i) disable iff (!rst_n)
    (wr_en_i && wr_addr_i[BUS_AW-1]) |-> (!glob_we && (win_we == '0)));
  // R8: channel enables on the outputs change only on a vsync
  p_chan_vsync_r8: assert property (@(posedge clk_i) disable iff (!rst_n)
    !vsync_i |=> $stable(chan_en_o));
endmodule

// File: tb/vsb_top_tb_top.sv
module vsb_top_tb_top;
  localparam int NW = 5;
  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_VS = 2'd2;

  typedef struct packed {
    logic [1:0]  op;
    logic [7:0]  addr;
    logic [31:0] data;
  } vec_t;

  localparam int NV = 33;
  localparam vec_t VEC [NV] = '{
    '{OP_WR, 8'h14, 32'h1000_0000},  // R2
    '{OP_RD, 8'h14, 32'h1000_0000},  // R2
    '{OP_RD, 8'h94, 32'h0000_0000},  // R7 shadow not yet taken
    '{OP_WR, 8'h10, 32'h0000_0001},
    '{OP_WR, 8'h18, 32'h0020_0010},
    '{OP_VS, 8'h00, 32'h0},
    '{OP_RD, 8'h94, 32'h1000_0000},  // R3 R7
    '{OP_RD, 8'h90, 32'h0000_0001},  // R3
    '{OP_RD, 8'h98, 32'h0020_0010},  // R3
    '{OP_WR, 8'h00, 32'h0000_0001},  // R4 protect window 0
    '{OP_WR, 8'h14, 32'h2000_0000},
    '{OP_VS, 8'h00, 32'h0},
    '{OP_RD, 8'h94, 32'h1000_0000},  // R4 frozen
    '{OP_RD, 8'h14, 32'h2000_0000},  // R7 working differs
    '{OP_WR, 8'h24, 32'hAAAA_0000},  // R9
    '{OP_VS, 8'h00, 32'h0},
    '{OP_RD, 8'hA4, 32'hAAAA_0000},  // R9 other window moves
    '{OP_WR, 8'h00, 32'h0000_0000},
    '{OP_RD, 8'h94, 32'h1000_0000},  // R4 clear alone does not copy
    '{OP_VS, 8'h00, 32'h0},
    '{OP_RD, 8'h94, 32'h2000_0000},  // R4 lands after clear
    '{OP_WR, 8'h00, 32'h0003_0000},  // R8
    '{OP_RD, 8'h80, 32'h0000_0000},  // R8
    '{OP_RD, 8'h00, 32'h0003_0000},  // R8 working
    '{OP_VS, 8'h00, 32'h0},
    '{OP_RD, 8'h80, 32'h0003_0000},  // R8
    '{OP_WR, 8'h28, 32'hFFFF_FFFF},
    '{OP_RD, 8'h28, 32'h0FFF_0FFF},  // R2 field masking
    '{OP_WR, 8'h7C, 32'hFFFF_FFFF},  // R10
    '{OP_RD, 8'h7C, 32'h0000_0000},  // R10
    '{OP_WR, 8'h94, 32'h1234_5678},  // R10 shadow read-only
    '{OP_RD, 8'h94, 32'h2000_0000},  // R10
    '{OP_RD, 8'h14, 32'h2000_0000}   // R10 working untouched
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          vsync, wr_en;
  logic [7:0]    wr_addr, rd_addr;
  logic [31:0]   wr_data, rd_data;
  logic [NW-1:0] win_en, chan_en;
  logic [NW*32-1:0] base;
  logic [NW*12-1:0] px, py;
  int total = 0;
  int bad   = 0;

  always #5ns clk = ~clk;

  vsb_top dut_i (
    .clk_i(clk), .rst_n_i(rst_n), .vsync_i(vsync), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .win_en_o(win_en), .chan_en_o(chan_en),
    .base_o(base), .pos_x_o(px), .pos_y_o(py)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [7:0] a, input logic [31:0] d, input logic vs);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d; vsync = vs;
    @(negedge clk);
    wr_en = 1'b0; vsync = 1'b0;
  endtask

  task automatic do_vs();
    @(negedge clk);
    vsync = 1'b1;
    @(negedge clk);
    vsync = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    rd_addr = a;
    #1ns;
    check(req, rd_data, exp);
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #2ms;
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    vsync = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 outputs in reset", {27'd0, win_en}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    rd_chk("R1 working base", 8'h14, 32'd0);
    rd_chk("R1 shadow base", 8'h94, 32'd0);
    rd_chk("R1 global word", 8'h00, 32'd0);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i].op)
        OP_WR: do_wr(VEC[i].addr, VEC[i].data, 1'b0);
        OP_VS: do_vs();
        default: rd_chk($sformatf("vector %0d", i), VEC[i].addr, VEC[i].data);
      endcase
    end

    @(negedge clk);
    check("R3 base_o window0", base[31:0], 32'h2000_0000);
    check("R3 pos_x_o window0", {20'd0, px[11:0]}, 32'h10);
    check("R3 pos_y_o window0", {20'd0, py[11:0]}, 32'h20);
    check("R8 chan_en_o", {27'd0, chan_en}, 32'h3);

    // R5: disable waits for the next vsync
    do_wr(8'h10, 32'h0, 1'b0);
    check("R5 enable held after clear", {31'd0, win_en[0]}, 32'd1);
    do_vs();
    check("R5 enable drops at vsync", {31'd0, win_en[0]}, 32'd0);

    // R6: write on the same clock as vsync
    do_wr(8'h34, 32'h0000_5555, 1'b1);
    rd_chk("R6 shadow keeps prior value", 8'hB4, 32'd0);
    rd_chk("R6 working took write", 8'h34, 32'h0000_5555);
    do_vs();
    rd_chk("R6 lands at next vsync", 8'hB4, 32'h0000_5555);
    check("R6 base_o window2", base[95:64], 32'h0000_5555);

    // R1: reset again clears everything
    apply_reset();
    rd_chk("R1 working after reset", 8'h34, 32'd0);
    rd_chk("R1 shadow after reset", 8'h94, 32'd0);
    rd_chk("R1 global after reset", 8'h00, 32'd0);
    check("R1 base_o after reset", base[31:0], 32'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule